// File: doc/BRIEF.md
# Double-Buffered Serial Converter Code Receiver

This block receives the code word for a digital-to-analog converter over three slow serial pins: a bit clock, a data line and a load strobe. All pins, plus an active-low clear pin, are oversampled by a fast system clock. Each pin passes through a two-flop synchronizer, and edges are found by comparing successive synchronized samples. For this to work, the system clock must run at least four times faster than the bit clock.

While the load strobe is high, every rising bit-clock edge shifts the data bit into an input shift register. The new bit enters at the least significant end, so words arrive most significant bit first. When the load strobe falls, the shift register is copied into a separate code register, which drives the converter. A one-cycle pulse marks each copy.

Because the two registers are separate, a new word can be shifted in without disturbing the code the converter is using. A word longer than the register keeps only its last N bits. A parameter selects a 12-bit or a 10-bit code.

Top module: `dac_serial_rx`

## Requirements
- R1: After system reset, `code` is zero and `xfer` is low.
- R2: Each rising `bclk_pin` edge seen while `load_pin` is high shifts `data_pin` into bit 0 of the shift register, and the earlier bits move one place toward the MSB. A falling `load_pin` edge copies the shift register into `code`, so N bits sent MSB first appear in `code` unchanged.
- R3: With `WIDE_CODE`=1, N is 12 and `code` is 12 bits wide. With `WIDE_CODE`=0, N is 10 and `code` is 10 bits wide.
- R4: When more than N bits are shifted in, only the last N bits are kept and the leading bits are dropped. For example, 16 bits 0xA5C3 give 0x5C3 at N=12 and 0x1C3 at N=10.
- R5: Rising `bclk_pin` edges seen while `load_pin` is low leave the shift register unchanged.
- R6: `code` changes only on a load-strobe falling edge or on a clear. Shifting and a rising `load_pin` edge leave it unchanged.
- R7: `code` takes its new value, and `xfer` is high for exactly one cycle, after the third rising system clock edge that follows a falling `load_pin` transition.
- R8: A low `clr_n` zeroes both the shift register and `code`. Clear overrides shifting and overrides a load edge that arrives at the same time; no `xfer` pulse occurs in that case.
- R9: After reset, `code` stays zero until the first falling `load_pin` edge, even if bits are shifted in before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| bclk_pin | input | 1 | External serial bit clock (asynchronous) |
| data_pin | input | 1 | External serial data, MSB first |
| load_pin | input | 1 | External load strobe; enables the bit clock while high, transfers on its fall |
| clr_n | input | 1 | External active-low clear of both registers |
| code | output | N (12 or 10) | Held converter code |
| xfer | output | 1 | One-cycle pulse on each transfer into `code` |

## Verification
Every pin reaches the edge logic two system clocks after it changes. Register updates therefore appear on the third rising clock after the pin change. The bench drives pins on falling clock edges and measures the load-to-code path exactly: `code` and `xfer` must be unchanged at the second falling edge after the strobe drops, updated at the third, and `xfer` must be low again at the fourth. Bits are spaced by three system clocks per half bit period, and every other check waits six clocks after the last pin change, which is well past the three-cycle latency. A width-12 instance and a width-10 instance share the same pins, so one stream checks both truncation widths.

// File: rtl/dac_serial_rx_pkg.sv
package dac_serial_rx_pkg;

  // Synchronized view of the external pins
  typedef struct packed {
    logic bclk;
    logic data;
    logic load;
    logic clr_n;
  } pin_bus_t;

  localparam int PIN_W = $bits(pin_bus_t);

  // Code width picked by the variant parameter
  function automatic int code_width(bit wide);
    return wide ? 12 : 10;
  endfunction

  function automatic logic rose(logic cur, logic prev);
    return cur & ~prev;
  endfunction

  function automatic logic fell(logic cur, logic prev);
    return ~cur & prev;
  endfunction

endpackage

// File: rtl/dac_pin_sync.sv
module dac_pin_sync #(
  parameter int STAGES = 2,
  parameter int W      = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  // chain[0] is the raw pin, chain[STAGES] the synchronized copy
  logic [W-1:0] chain [STAGES+1];

  assign chain[0] = din;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g+1] <= '0;
      else        chain[g+1] <= chain[g];
    end
  end

  assign dout = chain[STAGES];

endmodule

// File: rtl/dac_edge_det.sv
module dac_edge_det
  import dac_serial_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  pin_bus_t pins,
  output logic     shift_en,
  output logic     load_fall,
  output logic     data_bit,
  output logic     clr_act
);

  logic bclk_prev;
  logic load_prev;
  logic bclk_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_prev <= 1'b0;
      load_prev <= 1'b0;
    end else begin
      bclk_prev <= pins.bclk;
      load_prev <= pins.load;
    end
  end

  assign bclk_rise = rose(pins.bclk, bclk_prev);
  // bit clock honoured only while the strobe is high
  assign shift_en  = bclk_rise & pins.load;
  assign load_fall = fell(pins.load, load_prev);
  assign data_bit  = pins.data;
  assign clr_act   = ~pins.clr_n;

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    load_fall |=> !load_fall); // R7

  AST_NO_SHIFT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    load_fall |-> !shift_en); // R5

endmodule

// File: rtl/dac_shift_reg.sv
module dac_shift_reg #(
  parameter int N = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         data_bit,
  input  logic         clr_act,
  input  logic         load_lvl,
  output logic [N-1:0] sr
);

  // New bit enters at the LSB; the oldest bit falls off the top
  function automatic logic [N-1:0] push_lsb(logic [N-1:0] r, logic b);
    return {r[N-2:0], b};
  endfunction

  logic [N-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr_q <= '0;
    else if (clr_act)  sr_q <= '0;
    else if (shift_en) sr_q <= push_lsb(sr_q, data_bit);
  end

  assign sr = sr_q;

  AST_SHIFT_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !clr_act) |=> (sr_q[0] == $past(data_bit))); // R2

  AST_SHIFT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !clr_act) |=> (sr_q[N-1:1] == $past(sr_q[N-2:0]))); // R4

  AST_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_lvl && !clr_act) |=> $stable(sr_q)); // R5

endmodule

// File: rtl/dac_code_reg.sv
module dac_code_reg #(
  parameter int N = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_fall,
  input  logic         clr_act,
  input  logic [N-1:0] sr,
  output logic [N-1:0] code,
  output logic         xfer
);

  logic [N-1:0] code_q;
  logic         xfer_q;
  logic         do_xfer;

  assign do_xfer = load_fall & ~clr_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      xfer_q <= 1'b0;
    end else begin
      xfer_q <= do_xfer;
      if (clr_act)      code_q <= '0;
      else if (do_xfer) code_q <= sr;
    end
  end

  assign code = code_q;
  assign xfer = xfer_q;

  AST_XFER_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_q |-> (code_q == $past(sr))); // R2

  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_fall && !clr_act) |=> $stable(code_q)); // R6

  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_q |=> !xfer_q); // R7

  AST_CLR_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_act |=> !xfer_q); // R8

endmodule

// File: rtl/dac_serial_rx.sv
module dac_serial_rx
  import dac_serial_rx_pkg::*;
#(
  parameter bit WIDE_CODE   = 1'b1,
  parameter int SYNC_STAGES = 2,
  localparam int N          = code_width(WIDE_CODE)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bclk_pin,
  input  logic         data_pin,
  input  logic         load_pin,
  input  logic         clr_n,
  output logic [N-1:0] code,
  output logic         xfer
);

  pin_bus_t         raw_pins;
  logic [PIN_W-1:0] sync_vec;
  pin_bus_t         sync_pins;
  logic             shift_en;
  logic             load_fall;
  logic             data_bit;
  logic             clr_act;
  logic [N-1:0]     sr;

  assign raw_pins = '{bclk: bclk_pin, data: data_pin, load: load_pin, clr_n: clr_n};

  dac_pin_sync #(.STAGES(SYNC_STAGES), .W(PIN_W)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (raw_pins),
    .dout (sync_vec)
  );

  assign sync_pins = pin_bus_t'(sync_vec);

  dac_edge_det u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .pins     (sync_pins),
    .shift_en (shift_en),
    .load_fall(load_fall),
    .data_bit (data_bit),
    .clr_act  (clr_act)
  );

  dac_shift_reg #(.N(N)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(shift_en),
    .data_bit(data_bit),
    .clr_act (clr_act),
    .load_lvl(sync_pins.load),
    .sr      (sr)
  );

  dac_code_reg #(.N(N)) u_code (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_fall(load_fall),
    .clr_act  (clr_act),
    .sr       (sr),
    .code     (code),
    .xfer     (xfer)
  );

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr_act |=> (code == '0 && sr == '0)); // R8

  AST_WIDTH_OK: assert property (@(posedge clk) disable iff (!rst_n)
    ($bits(code) == N) && (N == 12 || N == 10)); // R3

endmodule

// File: tb/test_dac_serial_rx.sv
module test_dac_serial_rx;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk_pin = 1'b0;
  logic data_pin = 1'b0;
  logic load_pin = 1'b0;
  logic clr_n = 1'b1;
  logic [11:0] code_w;
  logic [9:0]  code_n;
  logic        xfer_w;
  logic        xfer_n;

  int n_checks = 0;
  int n_fail   = 0;
  int pulses_w = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  dac_serial_rx #(.WIDE_CODE(1'b1)) i_dac_serial_rx (
    .clk(clk), .rst_n(rst_n), .bclk_pin(bclk_pin), .data_pin(data_pin),
    .load_pin(load_pin), .clr_n(clr_n), .code(code_w), .xfer(xfer_w));

  dac_serial_rx #(.WIDE_CODE(1'b0)) i_dac_serial_rx_n (
    .clk(clk), .rst_n(rst_n), .bclk_pin(bclk_pin), .data_pin(data_pin),
    .load_pin(load_pin), .clr_n(clr_n), .code(code_n), .xfer(xfer_n));

  always @(posedge clk) if (xfer_w) pulses_w++;

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clock_bit(logic b);
    data_pin = b;
    hold(3);
    bclk_pin = 1'b1;
    hold(3);
    bclk_pin = 1'b0;
  endtask

  task automatic shift_word(logic [15:0] v, int nbits);
    for (int i = nbits - 1; i >= 0; i--) clock_bit(v[i]);
    hold(3);
  endtask

  task automatic set_load(logic v);
    load_pin = v;
    hold(6);
  endtask

  // R1, R9: reset state and hold until first load fall
  task automatic t_reset;
    hold(4);
    chk("R1 code after reset", 16'(code_w), 16'h0);
    chk("R1 xfer after reset", 16'(xfer_w), 16'h0);
    set_load(1'b1);
    shift_word(16'hFFF, 12);
    chk("R9 code before first fall", 16'(code_w), 16'h0);
    chk("R9 no pulse before first fall", 16'(pulses_w), 16'h0);
  endtask

  // R7: exact latency from strobe fall to code and pulse
  task automatic t_timing;
    load_pin = 1'b0;
    hold(2);
    chk("R7 code not yet at 2nd edge", 16'(code_w), 16'h0);
    chk("R7 xfer not yet at 2nd edge", 16'(xfer_w), 16'h0);
    hold(1);
    chk("R7 code at 3rd edge", 16'(code_w), 16'hFFF);
    chk("R7 xfer at 3rd edge", 16'(xfer_w), 16'h1);
    hold(1);
    chk("R7 xfer one cycle", 16'(xfer_w), 16'h0);
    hold(4);
  endtask

  // R2, R3, R6: exact-length words, both widths
  task automatic t_words;
    set_load(1'b1);
    shift_word(16'hABC, 12);
    chk("R6 code held while shifting", 16'(code_w), 16'hFFF);
    set_load(1'b0);
    chk("R2 wide 12-bit word", 16'(code_w), 16'hABC);
    chk("R3 narrow keeps low 10 bits", 16'(code_n), 16'h2BC);
    set_load(1'b1);
    shift_word(16'h35A, 10);
    set_load(1'b0);
    chk("R3 narrow 10-bit word", 16'(code_n), 16'h35A);
    chk("R2 wide after 10 more bits", 16'(code_w), 16'h35A);
  endtask

  // R4: over-long frame keeps the last N bits
  task automatic t_overlong;
    set_load(1'b1);
    shift_word(16'hA5C3, 16);
    set_load(1'b0);
    chk("R4 wide 16-bit frame", 16'(code_w), 16'h5C3);
    chk("R4 narrow 16-bit frame", 16'(code_n), 16'h1C3);
  endtask

  // R5, R6: clocks with strobe low ignored; rising strobe does not transfer
  task automatic t_gating;
    int p0;
    set_load(1'b1);
    shift_word(16'h123, 12);
    set_load(1'b0);
    chk("R2 word 0x123", 16'(code_w), 16'h123);
    shift_word(16'hE5E, 12);
    p0 = pulses_w;
    set_load(1'b1);
    chk("R6 rising strobe no transfer", 16'(pulses_w), 16'(p0));
    set_load(1'b0);
    chk("R5 clocks ignored with strobe low", 16'(code_w), 16'h123);
    chk("R5 narrow ignores too", 16'(code_n), 16'h123);
  endtask

  // R8: clear zeroes both registers and wins over a load edge
  task automatic t_clear;
    int p0;
    clr_n = 1'b0;
    hold(6);
    chk("R8 clear zeroes code", 16'(code_w), 16'h0);
    clr_n = 1'b1;
    hold(4);
    set_load(1'b1);
    set_load(1'b0);
    chk("R8 clear zeroed shift register", 16'(code_w), 16'h0);
    set_load(1'b1);
    shift_word(16'h7E7, 12);
    p0 = pulses_w;
    clr_n = 1'b0;
    load_pin = 1'b0;
    hold(6);
    chk("R8 clear beats load edge", 16'(code_w), 16'h0);
    chk("R8 no pulse under clear", 16'(pulses_w), 16'(p0));
    clr_n = 1'b1;
    hold(4);
  endtask

  initial begin
    hold(3);
    rst_n = 1'b1;
    t_reset();
    t_timing();
    t_words();
    t_overlong();
    t_gating();
    t_clear();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule